// File: doc/BRIEF.md
# Indexed PLL Configuration Register Bank

This block keeps the settings of up to eight clock synthesizers behind a single small window of software registers. Software first picks an instance by writing its number into a select/commit register. From then on the control registers show that instance's settings. Edits made through the control registers change only a shared set of staging registers. A second write to the select/commit register, with the commit bit set, copies the staged values into one instance in a single clock edge. Every instance sees its new multiplier, fraction, output divider, analog trim word and enables at the same time.

The bank also qualifies a raw lock input from each synthesizer. An instance is reported ready only after its lock input has stayed high for a programmable number of reference cycles. This count starts after the most recent commit to that instance. A status register collects the ready flags into a bitmap, with one bit per instance. Software programs the analog trim word with its recommended value before it programs the multiplier and fraction. Separate trim values suit general-purpose and USB-oriented synthesizers. The bank stores whatever value software writes.

Top module: `pll_cfg_bank`

## Requirements
- R1: After synchronous reset, every instance is disabled with all fields zero, the selected index is 0, and all registers and outputs read zero.
- R2: Writing the select/commit register (address 0) with index bits [3:0] and bit 8 clear changes the selected instance. Control reads then return that instance's committed values, and no instance's outputs change.
- R3: Writing address 0 with bit 8 set and a valid index copies the staged divider, enables, multiplier, fraction and analog word into that instance. The outputs show them one cycle after the write, even when that index differs from the selected one.
- R4: An index of 8 to 15 is not a valid instance. Such a write to address 0 changes neither the selection nor any instance, whatever bit 8 holds.
- R5: Reading address 0 returns the selected index in bits [3:0], and bit 8 always reads 0.
- R6: Address 1 holds the divider in bits [7:0], the synthesizer enable in bit 8, the lock-qualify enable in bit 9 and the divided-output enable in bit 10. Address 2 holds the multiplier in bits [31:24] and the fraction in bits [21:0]. All other bits read 0.
- R7: An instance's divided-output enable is driven only when both its committed synthesizer enable and its divided-output enable are set. Clearing only the divided-output enable and committing leaves the synthesizer enabled.
- R8: Status (address 4, read-only, writes ignored) bit i is 1 only while instance i has synthesizer enable and lock-qualify enable committed, and its lock input has been sampled high on delay+1 consecutive edges since the last commit to i. A commit to i, or a low lock input, clears the bit.
- R9: Address 5 holds the 16-bit lock qualification delay. With a delay of 0, the ready bit rises on the first edge after the commit at which the lock input is high.
- R10: Address 3 holds the 32-bit analog trim word. It is staged and committed per instance like the other fields.
- R11: Staged edits do not reach any output before a commit. Selecting an index without committing reloads the staging registers from that instance and discards the edits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| lock_in | input | 8 | Raw lock indication, one per instance |
| pll_en_o | output | 8 | Committed synthesizer enable per instance |
| div_en_o | output | 8 | Gated divided-output enable per instance |
| mul_o | output | 64 | Multiplier, 8 bits per instance |
| frac_o | output | 176 | Fraction, 22 bits per instance |
| div_o | output | 64 | Output divider, 8 bits per instance |
| acr_o | output | 256 | Analog trim word, 32 bits per instance |

## Verification
The hardest case to reach from the ports involves two instances at once. Staging holds one instance's values and is committed into a different index. Meanwhile a lock counter on another instance must be restarted by its own commit and not by the neighbour's. The stimulus reaches this case through a fixed sequence of writes. It commits instance 2 and lets it lock, and changes only its output gate while its lock input stays high. It then commits the same staged values into instance 7 without reselecting. A model in the bench tracks every slot, the staging state and each lock counter, and checks all outputs against it on every cycle.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int REG_W     = 32;
    localparam int MUL_W     = 8;
    localparam int FRAC_W    = 22;
    localparam int DIV_W     = 8;
    localparam int ACR_W     = 32;
    localparam int IDX_FLD_W = 4;

    localparam int MUL_LSB   = 24;
    localparam int COMMIT_BIT = 8;
    localparam int PEN_BIT   = 8;
    localparam int LKE_BIT   = 9;
    localparam int DEN_BIT   = 10;

    typedef enum logic [2:0] {
        A_SEL   = 3'd0,
        A_CTRL0 = 3'd1,
        A_CTRL1 = 3'd2,
        A_ACR   = 3'd3,
        A_STAT  = 3'd4,
        A_DLY   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [ACR_W-1:0]  acr;
        logic [MUL_W-1:0]  mul;
        logic [FRAC_W-1:0] frac;
        logic [DIV_W-1:0]  div;
        logic              pll_en;
        logic              lock_en;
        logic              div_en;
    } pll_cfg_t;

    function automatic logic [REG_W-1:0] pack_ctrl0(input pll_cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[DIV_W-1:0] = c.div;
        r[PEN_BIT]   = c.pll_en;
        r[LKE_BIT]   = c.lock_en;
        r[DEN_BIT]   = c.div_en;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl1(input pll_cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[MUL_LSB +: MUL_W] = c.mul;
        r[FRAC_W-1:0]       = c.frac;
        return r;
    endfunction

    function automatic pll_cfg_t apply_ctrl0(input pll_cfg_t c, input logic [REG_W-1:0] w);
        pll_cfg_t r;
        r         = c;
        r.div     = w[DIV_W-1:0];
        r.pll_en  = w[PEN_BIT];
        r.lock_en = w[LKE_BIT];
        r.div_en  = w[DEN_BIT];
        return r;
    endfunction

    function automatic pll_cfg_t apply_ctrl1(input pll_cfg_t c, input logic [REG_W-1:0] w);
        pll_cfg_t r;
        r      = c;
        r.mul  = w[MUL_LSB +: MUL_W];
        r.frac = w[FRAC_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/pll_lock_qual.sv
module pll_lock_qual #(
    parameter int LOCK_CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  logic                  arm,
    input  logic                  lock_in,
    input  logic [LOCK_CNT_W-1:0] dly,
    output logic                  ready
);

    logic [LOCK_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !arm || !lock_in) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (cnt_q == dly) begin
            ready <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    ready_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(lock_in));

    // R8
    restart_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !ready);

endmodule

// File: rtl/pll_slot.sv
module pll_slot
    import pll_cfg_pkg::*;
#(
    parameter int LOCK_CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  pll_cfg_t              cfg_d,
    input  logic                  lock_in,
    input  logic [LOCK_CNT_W-1:0] dly,
    output pll_cfg_t              cfg_q,
    output logic                  ready,
    output logic                  div_gate
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_d;
    end

    assign div_gate = cfg_q.pll_en & cfg_q.div_en;

    pll_lock_qual #(.LOCK_CNT_W(LOCK_CNT_W)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .arm     (cfg_q.pll_en & cfg_q.lock_en),
        .lock_in (lock_in),
        .dly     (dly),
        .ready   (ready)
    );

    // R11
    hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
    import pll_cfg_pkg::*;
#(
    parameter int NUM_PLL    = 8,
    parameter int LOCK_CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [2:0]                  addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    input  logic [NUM_PLL-1:0]          lock_in,
    output logic [NUM_PLL-1:0]          pll_en_o,
    output logic [NUM_PLL-1:0]          div_en_o,
    output logic [NUM_PLL*MUL_W-1:0]    mul_o,
    output logic [NUM_PLL*FRAC_W-1:0]   frac_o,
    output logic [NUM_PLL*DIV_W-1:0]    div_o,
    output logic [NUM_PLL*ACR_W-1:0]    acr_o
);

    localparam int IDX_W = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;

    pll_cfg_t              stage_q;
    pll_cfg_t              slot_q [NUM_PLL];
    logic [IDX_W-1:0]      sel_q;
    logic [LOCK_CNT_W-1:0] dly_q;
    logic [NUM_PLL-1:0]    ready_vec;
    logic [NUM_PLL-1:0]    load_vec;

    logic [IDX_FLD_W-1:0]  wr_idx;
    logic                  idx_ok;
    logic                  sel_wr;
    logic                  commit;

    assign wr_idx = wdata[IDX_FLD_W-1:0];
    assign idx_ok = 32'(wr_idx) < NUM_PLL;
    assign sel_wr = wr_en && (reg_addr_e'(addr) == A_SEL) && idx_ok;
    assign commit = sel_wr && wdata[COMMIT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            sel_q   <= '0;
            dly_q   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_SEL: if (idx_ok) begin
                    sel_q <= IDX_W'(wr_idx);
                    if (!wdata[COMMIT_BIT])
                        stage_q <= slot_q[IDX_W'(wr_idx)];
                end
                A_CTRL0: stage_q     <= apply_ctrl0(stage_q, wdata);
                A_CTRL1: stage_q     <= apply_ctrl1(stage_q, wdata);
                A_ACR:   stage_q.acr <= wdata[ACR_W-1:0];
                A_DLY:   dly_q       <= wdata[LOCK_CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_SEL:   rdata = REG_W'(sel_q);
            A_CTRL0: rdata = pack_ctrl0(stage_q);
            A_CTRL1: rdata = pack_ctrl1(stage_q);
            A_ACR:   rdata = REG_W'(stage_q.acr);
            A_STAT:  rdata = REG_W'(ready_vec);
            A_DLY:   rdata = REG_W'(dly_q);
            default: rdata = '0;
        endcase
    end

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_slot
        assign load_vec[i] = commit && (32'(wr_idx) == i);

        pll_slot #(.LOCK_CNT_W(LOCK_CNT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (load_vec[i]),
            .cfg_d    (stage_q),
            .lock_in  (lock_in[i]),
            .dly      (dly_q),
            .cfg_q    (slot_q[i]),
            .ready    (ready_vec[i]),
            .div_gate (div_en_o[i])
        );

        assign pll_en_o[i]                  = slot_q[i].pll_en;
        assign mul_o[i*MUL_W +: MUL_W]      = slot_q[i].mul;
        assign frac_o[i*FRAC_W +: FRAC_W]   = slot_q[i].frac;
        assign div_o[i*DIV_W +: DIV_W]      = slot_q[i].div;
        assign acr_o[i*ACR_W +: ACR_W]      = slot_q[i].acr;

        // R3
        commit_copies_stage_chk: assert property (@(posedge clk) disable iff (rst)
            load_vec[i] |=> slot_q[i] == $past(stage_q));
    end

    // R4
    bad_index_keeps_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr_e'(addr) == A_SEL && !idx_ok) |=> $stable(sel_q));

    // R8
    single_slot_load_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(load_vec) <= 1);

endmodule

// File: tb/pll_cfg_bank_test.sv
`timescale 1ns/1ps
module pll_cfg_bank_test;

    localparam int N  = 8;
    localparam int CW = 16;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst   = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [N-1:0] lock_in = '0;
    wire  [31:0] rdata;
    wire  [N-1:0] pll_en_o, div_en_o;
    wire  [N*8-1:0]  mul_o, div_o;
    wire  [N*22-1:0] frac_o;
    wire  [N*32-1:0] acr_o;

    pll_cfg_bank #(.NUM_PLL(N), .LOCK_CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lock_in(lock_in), .pll_en_o(pll_en_o),
        .div_en_o(div_en_o), .mul_o(mul_o), .frac_o(frac_o),
        .div_o(div_o), .acr_o(acr_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit cmp_on = 0;

    // behavioural reference state
    logic [7:0]  m_mul [N];
    logic [21:0] m_frac[N];
    logic [7:0]  m_div [N];
    logic [31:0] m_acr [N];
    bit          m_pen [N];
    bit          m_lke [N];
    bit          m_den [N];
    int          m_cnt [N];
    bit          m_rdy [N];
    logic [7:0]  s_mul, s_div;
    logic [21:0] s_frac;
    logic [31:0] s_acr;
    bit          s_pen, s_lke, s_den;
    int          m_dly;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int ix;
        bit upd;
        ix  = int'(wdata[3:0]);
        upd = wdata[8];
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_mul[i] = 0; m_frac[i] = 0; m_div[i] = 0; m_acr[i] = 0;
                m_pen[i] = 0; m_lke[i] = 0; m_den[i] = 0; m_cnt[i] = 0; m_rdy[i] = 0;
            end
            s_mul = 0; s_div = 0; s_frac = 0; s_acr = 0;
            s_pen = 0; s_lke = 0; s_den = 0; m_dly = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit restart;
                restart = wr_en && addr == 3'd0 && ix < N && upd && ix == i;
                if (restart || !(m_pen[i] && m_lke[i]) || !lock_in[i]) begin
                    m_cnt[i] = 0; m_rdy[i] = 0;
                end else if (m_cnt[i] == m_dly) begin
                    m_rdy[i] = 1;
                end else begin
                    m_cnt[i]++;
                end
            end
            if (wr_en) begin
                case (addr)
                    3'd0: if (ix < N) begin
                        if (upd) begin
                            m_mul[ix] = s_mul; m_frac[ix] = s_frac; m_div[ix] = s_div;
                            m_acr[ix] = s_acr; m_pen[ix] = s_pen; m_lke[ix] = s_lke;
                            m_den[ix] = s_den;
                        end else begin
                            s_mul = m_mul[ix]; s_frac = m_frac[ix]; s_div = m_div[ix];
                            s_acr = m_acr[ix]; s_pen = m_pen[ix]; s_lke = m_lke[ix];
                            s_den = m_den[ix];
                        end
                    end
                    3'd1: begin s_div = wdata[7:0]; s_pen = wdata[8]; s_lke = wdata[9]; s_den = wdata[10]; end
                    3'd2: begin s_mul = wdata[31:24]; s_frac = wdata[21:0]; end
                    3'd3: s_acr = wdata;
                    3'd5: m_dly = int'(wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin : compare
        logic [N*8-1:0]  e_mul, e_div;
        logic [N*22-1:0] e_frac;
        logic [N*32-1:0] e_acr;
        logic [N-1:0]    e_pen, e_den, e_rdy;
        if (cmp_on && !done) begin
            for (int i = 0; i < N; i++) begin
                e_mul[i*8 +: 8]   = m_mul[i];
                e_div[i*8 +: 8]   = m_div[i];
                e_frac[i*22 +: 22] = m_frac[i];
                e_acr[i*32 +: 32] = m_acr[i];
                e_pen[i] = m_pen[i];
                e_den[i] = m_pen[i] & m_den[i];
                e_rdy[i] = m_rdy[i];
            end
            chk({mul_o, div_o, pll_en_o} === {e_mul, e_div, e_pen}, "R3 mul/div/enable outputs",
                256'({mul_o, div_o, pll_en_o}), 256'({e_mul, e_div, e_pen}));
            chk(frac_o === e_frac, "R3 fraction outputs", 256'(frac_o), 256'(e_frac));
            chk(acr_o === e_acr, "R10 analog outputs", acr_o, e_acr);
            chk(div_en_o === e_den, "R7 divided output gate", 256'(div_en_o), 256'(e_den));
            chk(uut.rdata === uut.rdata && (addr != 3'd4 || rdata[N-1:0] === e_rdy), "R8 status bitmap",
                256'(rdata), 256'(e_rdy));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        addr = a;
        #1 chk(rdata === exp, tag, 256'(rdata), 256'(exp));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cmp_on = 1;

        rd(3'd0, 32'h0, "R1 select after reset");
        rd(3'd1, 32'h0, "R1 ctrl0 after reset");
        rd(3'd2, 32'h0, "R1 ctrl1 after reset");
        rd(3'd4, 32'h0, "R1 status after reset");
        chk(pll_en_o === '0 && mul_o === '0, "R1 outputs after reset", 256'({pll_en_o, mul_o}), 256'(0));

        wr(3'd5, 32'd3);
        rd(3'd5, 32'd3, "R9 delay readback");
        wr(3'd2, 32'h31AA_AAAA);
        rd(3'd2, 32'h312A_AAAA, "R6 ctrl1 field masking");
        wr(3'd1, 32'hFFFF_F705);
        rd(3'd1, 32'h0000_0705, "R6 ctrl0 field masking");
        wr(3'd3, 32'h0000_1234);
        rd(3'd3, 32'h0000_1234, "R10 analog staging");
        chk(mul_o === '0 && pll_en_o === '0, "R11 staged edits not visible", 256'({mul_o, pll_en_o}), 256'(0));

        wr(3'd0, 32'h0000_0102);
        lock_in = 8'h04;
        @(negedge clk);
        chk(mul_o[23:16] === 8'h31 && div_o[23:16] === 8'h05, "R3 commit slot 2", 256'({mul_o[23:16], div_o[23:16]}), 256'(16'h3105));
        chk(frac_o[65:44] === 22'h2A_AAAA, "R3 commit fraction", 256'(frac_o[65:44]), 256'(22'h2AAAAA));
        chk(acr_o[95:64] === 32'h1234, "R10 analog commit", 256'(acr_o[95:64]), 256'(32'h1234));
        chk(pll_en_o === 8'h04 && div_en_o === 8'h04, "R7 both enables", 256'({pll_en_o, div_en_o}), 256'(16'h0404));
        rd(3'd4, 32'h0, "R8 ready not yet");
        repeat (6) @(posedge clk);
        rd(3'd4, 32'h4, "R8 ready after delay");

        wr(3'd0, 32'h0000_0005);
        rd(3'd2, 32'h0, "R2 ctrl1 of slot 5");
        rd(3'd1, 32'h0, "R2 ctrl0 of slot 5");
        rd(3'd0, 32'h5, "R5 select readback");
        chk(mul_o[23:16] === 8'h31 && pll_en_o === 8'h04, "R2 select commits nothing", 256'({mul_o[23:16], pll_en_o}), 256'(16'h3104));

        wr(3'd0, 32'h0000_0109);
        rd(3'd0, 32'h5, "R4 bad index ignored");
        chk(pll_en_o === 8'h04, "R4 no slot written", 256'(pll_en_o), 256'(8'h04));

        wr(3'd0, 32'h0000_0002);
        rd(3'd2, 32'h312A_AAAA, "R2 readback of slot 2");
        wr(3'd1, 32'h0000_0305);
        wr(3'd0, 32'h0000_0102);
        @(negedge clk);
        chk(div_en_o === 8'h00 && pll_en_o === 8'h04, "R7 gate off, synth on", 256'({div_en_o, pll_en_o}), 256'(16'h0004));
        repeat (8) @(posedge clk);
        rd(3'd4, 32'h4, "R8 relock after commit");
        rd(3'd0, 32'h2, "R5 commit bit reads 0");

        wr(3'd0, 32'h0000_0107);
        @(negedge clk);
        chk(pll_en_o === 8'h84 && mul_o[63:56] === 8'h31, "R3 commit to other slot", 256'({pll_en_o, mul_o[63:56]}), 256'(16'h8431));
        chk(acr_o[255:224] === 32'h1234, "R10 analog to other slot", 256'(acr_o[255:224]), 256'(32'h1234));
        chk(acr_o[191:160] === 32'h0, "R10 slot 5 untouched", 256'(acr_o[191:160]), 256'(0));

        @(negedge clk); #1 lock_in = 8'h00;
        repeat (2) @(posedge clk);
        rd(3'd4, 32'h0, "R8 lock loss clears");

        @(negedge clk); #1 lock_in = 8'hFF;
        wr(3'd1, 32'h0000_0105);
        wr(3'd0, 32'h0000_0107);
        repeat (8) @(posedge clk);
        rd(3'd4, 32'h4, "R8 lock enable gates status");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'h4, "R8 status write ignored");

        wr(3'd2, 32'hFF00_0000);
        wr(3'd0, 32'h0000_0007);
        rd(3'd2, 32'h312A_AAAA, "R11 reselect discards edit");
        chk(mul_o[63:56] === 8'h31, "R11 discarded edit not visible", 256'(mul_o[63:56]), 256'(8'h31));

        wr(3'd5, 32'd0);
        wr(3'd0, 32'h0000_0002);
        wr(3'd0, 32'h0000_0102);
        rd(3'd4, 32'h0, "R9 delay 0 before edge");
        rd(3'd4, 32'h4, "R9 delay 0 one edge");

        repeat (2) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule